// File: doc/BRIEF.md
# Receive descriptor writeback engine

This block is the receive-side DMA control of an Ethernet MAC. Software lays out a chain of 16-byte descriptors in memory and hands each one to hardware by setting its two ownership bits. When a frame starts on the incoming byte stream, the engine reads the current descriptor over a 32-bit word master port. If hardware owns the descriptor, the engine also reads the buffer address. It then packs the payload into words and writes them to the buffer.

When the last byte has been stored, the engine writes the status and length word back to the descriptor. This write returns ownership to software. The engine then reads the next-descriptor pointer and moves to it. Three conditions discard the frame instead and raise an event: a descriptor that hardware does not own, an oversized frame while long frames are refused, and an error response from memory. Address filtering and CRC checking are done elsewhere. The reported length includes four CRC bytes that the stream does not carry.

Top module: `rx_desc_wb`

## Requirements
- R1: During reset, no memory request is made, no event fires and `cur_desc` is 0. While `rx_en` is low and the engine is idle, `cur_desc` follows `list_base` and `rx_ready` stays low.
- R2: A descriptor occupies 16 bytes starting at `cur_desc`. Word 0 (offset 0) holds status and length, offset 4 holds the buffer address and offset 12 holds the next-descriptor pointer. The word at offset 8 is never accessed.
- R3: Hardware owns a descriptor only when bits 31:30 of word 0 equal 2'b10. For any other pattern, the frame is discarded and `ev_unavail` pulses. The descriptor and `cur_desc` are left unchanged.
- R4: Payload byte i is stored in the word at buffer address + 4*(i/4), in lane i%4 (bits 8*(i%4)+7 : 8*(i%4)). Unused lanes of the final word are zero.
- R5: The status word written back has bits 31:30 = 00, bit 20 = 1, bit 19 = too-long and bit 16 = `irq_en`. Bits 15:0 hold the byte count plus 4. All other bits are zero.
- R6: After a frame completes, `ev_good`, `ev_early` and `ev_intr` pulse for one cycle. In that same cycle `cur_desc` takes the next-descriptor pointer. `cur_desc` changes at no other time while `rx_en` is high.
- R7: With `long_ok` high, a frame whose reported length exceeds MAX_FRAME is stored in full. It gets status bit 19, and `ev_too_long` pulses together with `ev_good`.
- R8: With `long_ok` low, a frame whose reported length exceeds MAX_FRAME is discarded and `ev_max_len` pulses. The descriptor and `cur_desc` are left unchanged. A reported length equal to MAX_FRAME is accepted as a normal frame.
- R9: An error response from memory aborts the frame, discards its remaining bytes and pulses `ev_bus_err`. `cur_desc` is not advanced.
- R10: `poll_req` has no effect. Frames are taken without it, and pulsing it while idle starts no memory access.
- R11: `mem_req` stays high until `mem_ack` or `mem_err`, and `mem_addr`, `mem_we` and `mem_wdata` stay stable while it waits.
- R12: At most one of `ev_good`, `ev_unavail`, `ev_max_len` and `ev_bus_err` fires in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| long_ok | input | 1 | Accept frames above MAX_FRAME |
| irq_en | input | 1 | Sets status bit 16 on completed frames |
| poll_req | input | 1 | Poll-demand strobe (no effect) |
| list_base | input | 32 | First descriptor address, loaded while disabled |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request done |
| mem_err | input | 1 | Request failed |
| cur_desc | output | 32 | Current descriptor address |
| ev_good | output | 1 | Frame stored and handed back |
| ev_early | output | 1 | Early DMA notification |
| ev_intr | output | 1 | Receive interrupt event |
| ev_too_long | output | 1 | Oversized frame stored |
| ev_max_len | output | 1 | Oversized frame discarded |
| ev_unavail | output | 1 | No hardware-owned descriptor |
| ev_bus_err | output | 1 | Memory error response |

## Verification
The bench builds the engine with MAX_FRAME set to 96. This brings both sides of the length limit within reach using frames of about a hundred bytes: stored-and-flagged, discarded, and exactly at the limit. The bench memory answers after 0, 1 or 3 wait cycles, so the request-hold rule and the word packing are exercised under stalls. Error responses are injected on a payload word and on the next-pointer read. These cover both the mid-frame abort and the abort after writeback.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int LEN_FIELD_W = 16;
  localparam logic [1:0] OWN_HW = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_BUF, ST_DATA, ST_WR, ST_WB, ST_NXT, ST_DROP
  } rxd_state_e;

  typedef enum logic [1:0] {
    DR_UNAV, DR_MAXL, DR_BERR
  } rxd_drop_e;

  // Status word handed back to software on completion
  function automatic logic [31:0] rxd_status(input logic [LEN_FIELD_W-1:0] len,
                                             input logic long_f,
                                             input logic irq);
    return {2'b00, 9'd0, 1'b1, long_f, 2'b00, irq, len};
  endfunction

  // Place one byte into its little-endian lane
  function automatic logic [31:0] rxd_lane_put(input logic [31:0] w,
                                               input logic [7:0] b,
                                               input logic [1:0] lane);
    logic [31:0] r;
    r = w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/rxd_meter.sv
module rxd_meter #(
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 1518,
  parameter int CRC_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic             over_next,
  output logic             too_long,
  output logic [LEN_W-1:0] rep_len
);
  logic [LEN_W-1:0] count_q;

  assign over_next = (32'(count_q) + 32'd1 + 32'(CRC_BYTES)) > 32'(MAX_FRAME);
  assign rep_len   = count_q + LEN_W'(CRC_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count_q  <= '0;
      too_long <= 1'b0;
    end else if (step) begin
      count_q  <= count_q + 1'b1;
      if (over_next) too_long <= 1'b1;
    end
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic [7:0]  byte_in,
  output logic [31:0] word_q,
  output logic [1:0]  lane_q
);
  import rxd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word_q <= '0;
      lane_q <= '0;
    end else if (load) begin
      word_q <= rxd_lane_put(word_q, byte_in, lane_q);
      lane_q <= lane_q + 2'd1;
    end
  end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb #(
  parameter int LEN_W      = 16,
  parameter int MAX_FRAME  = 1518,
  parameter int CRC_BYTES  = 4,
  parameter int DESC_WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        long_ok,
  input  logic        irq_en,
  input  logic        poll_req,
  input  logic [31:0] list_base,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic [31:0] cur_desc,
  output logic        ev_good,
  output logic        ev_early,
  output logic        ev_intr,
  output logic        ev_too_long,
  output logic        ev_max_len,
  output logic        ev_unavail,
  output logic        ev_bus_err
);
  import rxd_pkg::*;

  localparam logic [31:0] OFF_BUF = 32'd4;
  localparam logic [31:0] OFF_NXT = 32'((DESC_WORDS - 1) * 4);

  rxd_state_e       state_q;
  rxd_drop_e        reason_q;
  logic [31:0]      cur_q, buf_q;
  logic [LEN_W-1:0] wcnt_q;
  logic             last_q, irq_q;

  // Named internal events, also seen by the checker
  logic accept, drop_byte, pk_load, pk_clear, wb_phase;
  logic over_next, too_long;
  logic [LEN_W-1:0] rep_len;
  logic [31:0] word_q;
  logic [1:0]  lane_q;

  assign rx_ready  = (state_q == ST_DATA) || (state_q == ST_DROP);
  assign accept    = rx_valid && rx_ready;
  assign drop_byte = (state_q == ST_DATA) && accept && over_next && !long_ok;
  assign pk_load   = (state_q == ST_DATA) && accept && !drop_byte;
  assign pk_clear  = (state_q == ST_IDLE) || ((state_q == ST_WR) && mem_ack);
  assign wb_phase  = (state_q == ST_WB);
  assign cur_desc  = cur_q;

  rxd_meter #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .CRC_BYTES(CRC_BYTES)) u_meter (
    .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
    .step((state_q == ST_DATA) && accept),
    .over_next(over_next), .too_long(too_long), .rep_len(rep_len)
  );

  rxd_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pk_clear), .load(pk_load),
    .byte_in(rx_data), .word_q(word_q), .lane_q(lane_q)
  );

  // Memory request decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_OWN: mem_req = 1'b1;
      ST_BUF: begin mem_req = 1'b1; mem_addr = cur_q + OFF_BUF; end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + 32'({wcnt_q, 2'b00});
        mem_wdata = word_q;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = rxd_status(LEN_FIELD_W'(rep_len), too_long, irq_q);
      end
      ST_NXT: begin mem_req = 1'b1; mem_addr = cur_q + OFF_NXT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      reason_q <= DR_UNAV;
      cur_q    <= '0;
      buf_q    <= '0;
      wcnt_q   <= '0;
      last_q   <= 1'b0;
      irq_q    <= 1'b0;
      ev_good <= 1'b0; ev_early <= 1'b0; ev_intr <= 1'b0; ev_too_long <= 1'b0;
      ev_max_len <= 1'b0; ev_unavail <= 1'b0; ev_bus_err <= 1'b0;
    end else begin
      ev_good <= 1'b0; ev_early <= 1'b0; ev_intr <= 1'b0; ev_too_long <= 1'b0;
      ev_max_len <= 1'b0; ev_unavail <= 1'b0; ev_bus_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!rx_en) cur_q <= list_base;
          else if (rx_valid) state_q <= ST_OWN;
        end
        ST_OWN: begin
          if (mem_err) begin
            reason_q <= DR_BERR;
            state_q  <= ST_DROP;
          end else if (mem_ack) begin
            if (mem_rdata[31:30] == OWN_HW) state_q <= ST_BUF;
            else begin
              reason_q <= DR_UNAV;
              state_q  <= ST_DROP;
            end
          end
        end
        ST_BUF: begin
          if (mem_err) begin
            reason_q <= DR_BERR;
            state_q  <= ST_DROP;
          end else if (mem_ack) begin
            buf_q   <= mem_rdata;
            wcnt_q  <= '0;
            irq_q   <= irq_en;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (accept) begin
            if (drop_byte) begin
              if (rx_last) begin
                ev_max_len <= 1'b1;
                state_q    <= ST_IDLE;
              end else begin
                reason_q <= DR_MAXL;
                state_q  <= ST_DROP;
              end
            end else if (rx_last || (lane_q == 2'd3)) begin
              last_q  <= rx_last;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_err) begin
            if (last_q) begin
              ev_bus_err <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              reason_q <= DR_BERR;
              state_q  <= ST_DROP;
            end
          end else if (mem_ack) begin
            wcnt_q  <= wcnt_q + 1'b1;
            state_q <= last_q ? ST_WB : ST_DATA;
          end
        end
        ST_WB: begin
          if (mem_err) begin
            ev_bus_err <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (mem_ack) state_q <= ST_NXT;
        end
        ST_NXT: begin
          if (mem_err) begin
            ev_bus_err <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (mem_ack) begin
            cur_q       <= mem_rdata;
            ev_good     <= 1'b1;
            ev_early    <= 1'b1;
            ev_intr     <= 1'b1;
            ev_too_long <= too_long;
            state_q     <= ST_IDLE;
          end
        end
        ST_DROP: begin
          if (accept && rx_last) begin
            unique case (reason_q)
              DR_UNAV: ev_unavail <= 1'b1;
              DR_MAXL: ev_max_len <= 1'b1;
              default: ev_bus_err <= 1'b1;
            endcase
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_en,
  input logic        poll_req,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] cur_desc,
  input logic        ev_good,
  input logic        ev_early,
  input logic        ev_too_long,
  input logic        ev_max_len,
  input logic        ev_unavail,
  input logic        ev_bus_err,
  input logic        wb_phase
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_good, ev_unavail, ev_max_len, ev_bus_err})); // R12

  AST_LONG_IS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_too_long |-> ev_good); // R7

  AST_EARLY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_good |-> ev_early); // R6

  AST_CUR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_en) && !ev_good) |-> $stable(cur_desc)); // R6

  AST_WB_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_phase |-> (mem_we && mem_wdata[31:30] == 2'b00 && mem_wdata[20])); // R5

  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !mem_req && !rx_valid) |=> !mem_req); // R10
endmodule

bind rx_desc_wb rxd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_en(rx_en), .poll_req(poll_req),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_err(mem_err), .cur_desc(cur_desc),
  .ev_good(ev_good), .ev_early(ev_early), .ev_too_long(ev_too_long),
  .ev_max_len(ev_max_len), .ev_unavail(ev_unavail), .ev_bus_err(ev_bus_err),
  .wb_phase(wb_phase)
);

// File: tb/sim_rx_desc_wb.sv
module sim_rx_desc_wb;
  localparam int MAXF = 96;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_en, long_ok, irq_en, poll_req;
  logic [31:0] list_base;
  logic rx_valid, rx_last, rx_ready;
  logic [7:0] rx_data;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic ev_good, ev_early, ev_intr, ev_too_long, ev_max_len, ev_unavail, ev_bus_err;

  rx_desc_wb #(.MAX_FRAME(MAXF)) u0 (.*);

  int n_chk = 0, n_fail = 0, cyc_bad = 0;
  logic done = 1'b0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural word memory with latency and error injection
  logic [31:0] mem [int unsigned];
  int lat = 0, lat_cnt = 0, txn = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; lat_cnt = 0;
    end else if (mem_ack || mem_err) begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt < lat) lat_cnt++;
      else begin
        lat_cnt = 0;
        txn++;
        if (mem_addr == err_addr) mem_err <= 1'b1;
        else begin
          mem_ack <= 1'b1;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata <= mrd(mem_addr);
        end
      end
    end
  end

  // Reference for the descriptor pointer, compared every clock
  logic [31:0] exp_cur;
  always @(posedge clk) begin
    if (!rst_n) exp_cur <= '0;
    else if (mem_ack && !mem_we && mem_addr == exp_cur + 32'd12) exp_cur <= mem_rdata;
    else if (!rx_en) exp_cur <= list_base;
  end

  int ec[7];
  int sn[7];
  initial for (int k = 0; k < 7; k++) begin ec[k] = 0; sn[k] = 0; end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cur_desc !== exp_cur) begin
        cyc_bad++;
        if (cyc_bad < 5) $display("FAIL R6 per-cycle cur_desc actual=%h expected=%h", cur_desc, exp_cur);
      end
      ec[0] += int'(ev_good);    ec[1] += int'(ev_early); ec[2] += int'(ev_intr);
      ec[3] += int'(ev_too_long); ec[4] += int'(ev_max_len);
      ec[5] += int'(ev_unavail); ec[6] += int'(ev_bus_err);
    end
  end

  function automatic logic [7:0] bval(input int s, input int i);
    return 8'((s * 29 + i * 13 + 5) & 255);
  endfunction

  function automatic logic [31:0] exp_word(input int s, input int n, input int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < n) w[8*b +: 8] = bval(s, 4 * k + b);
    return w;
  endfunction

  task automatic send(input int n, input int s);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = bval(s, i); rx_last = (i == n - 1);
      forever begin
        logic took;
        took = rx_ready;
        @(negedge clk);
        if (took) break;
      end
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic snap();
    for (int k = 0; k < 7; k++) sn[k] = ec[k];
  endtask

  // order: good, early, intr, too_long, max_len, unavail, bus_err
  task automatic chk_ev(input string tag, input int g, input int tl, input int ml,
                        input int un, input int be);
    int e[7];
    e = '{g, g, g, tl, ml, un, be};
    for (int k = 0; k < 7; k++)
      check($sformatf("%s event %0d", tag, k), 32'(ec[k] - sn[k]), 32'(e[k]));
  endtask

  task automatic chk_store(input string tag, input logic [31:0] ba, input int n, input int s);
    for (int k = 0; k < (n + 3) / 4; k++)
      check($sformatf("%s word %0d", tag, k), mrd(ba + 32'(4 * k)), exp_word(s, n, k));
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] b, input logic [31:0] nx);
    mem[a] = w0; mem[a + 4] = b; mem[a + 12] = nx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int t0;
    logic saw;
    rst_n = 1'b0; rx_en = 1'b0; long_ok = 1'b0; irq_en = 1'b0; poll_req = 1'b0;
    list_base = 32'h1000; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset mem_req", 32'(mem_req), 0);
    check("R1 reset rx_ready", 32'(rx_ready), 0);
    check("R1 reset cur_desc", cur_desc, 0);
    check("R1 reset events", 32'({ev_good, ev_unavail, ev_max_len, ev_bus_err, ev_too_long}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 disabled cur follows base", cur_desc, 32'h1000);

    put_desc(32'h1000, 32'h8000_0000, 32'h2000, 32'h1010);
    put_desc(32'h1010, 32'h8000_0000, 32'h3000, 32'h1020);
    put_desc(32'h1020, 32'h0000_0000, 32'h4000, 32'h1030);
    put_desc(32'h1030, 32'h8000_0000, 32'h5000, 32'h1040);
    put_desc(32'h1040, 32'h8000_0000, 32'h6000, 32'h1050);
    put_desc(32'h1050, 32'h8000_0000, 32'h7000, 32'h1060);
    rx_en = 1'b1;
    repeat (2) @(negedge clk);

    // R10: poll pulses while idle start no access
    t0 = txn;
    for (int i = 0; i < 5; i++) begin
      poll_req = 1'b1; @(negedge clk); poll_req = 1'b0; @(negedge clk);
    end
    check("R10 poll while idle memory accesses", 32'(txn - t0), 0);
    check("R10 poll while idle cur_desc", cur_desc, 32'h1000);

    // F1: 64 bytes, interrupt bit off
    snap(); send(64, 1);
    check("R5 F1 status word", mrd(32'h1000), 32'h0010_0044);
    chk_store("R4 F1 payload", 32'h2000, 64, 1);
    check("R2 F1 reserved word untouched", mrd(32'h1008), 0);
    check("R2 F1 buffer word untouched", mrd(32'h1004), 32'h2000);
    check("R6 F1 cur_desc advanced", cur_desc, 32'h1010);
    chk_ev("R6 F1", 1, 0, 0, 0, 0);

    // F2: 5 bytes, partial word, interrupt bit on, poll held, latency 1
    lat = 1; irq_en = 1'b1; poll_req = 1'b1;
    snap(); send(5, 2);
    poll_req = 1'b0; irq_en = 1'b0;
    check("R5 F2 status with interrupt bit", mrd(32'h1010), 32'h0011_0009);
    chk_store("R4 F2 zero-filled tail", 32'h3000, 5, 2);
    check("R10 F2 cur_desc with poll held", cur_desc, 32'h1020);
    chk_ev("R6 F2", 1, 0, 0, 0, 0);

    // F3/F4: descriptor owned by software (00), then pattern 11
    snap(); send(10, 3);
    check("R3 F3 owner 00 descriptor untouched", mrd(32'h1020), 0);
    check("R3 F3 no payload stored", mrd(32'h4000), 0);
    check("R3 F3 cur_desc held", cur_desc, 32'h1020);
    chk_ev("R3 F3", 0, 0, 0, 1, 0);
    mem[32'h1020] = 32'hC000_0000;
    snap(); send(6, 4);
    check("R3 F4 owner 11 descriptor untouched", mrd(32'h1020), 32'hC000_0000);
    chk_ev("R3 F4", 0, 0, 0, 1, 0);

    // F5: oversize with long frames accepted, latency 3
    mem[32'h1020] = 32'h8000_0000; long_ok = 1'b1; lat = 3;
    snap(); send(120, 5);
    check("R7 F5 status too-long", mrd(32'h1020), 32'h0018_007C);
    chk_store("R7 F5 full payload", 32'h4000, 120, 5);
    check("R7 F5 cur_desc", cur_desc, 32'h1030);
    chk_ev("R7 F5", 1, 1, 0, 0, 0);

    // F6: oversize refused
    long_ok = 1'b0; lat = 0;
    snap(); send(120, 6);
    check("R8 F6 descriptor untouched", mrd(32'h1030), 32'h8000_0000);
    check("R8 F6 cur_desc held", cur_desc, 32'h1030);
    chk_ev("R8 F6", 0, 0, 1, 0, 0);

    // F7: reported length exactly at the limit
    snap(); send(MAXF - 4, 7);
    check("R8 F7 at-limit status", mrd(32'h1030), 32'h0010_0000 | 32'(MAXF));
    check("R8 F7 cur_desc", cur_desc, 32'h1040);
    chk_ev("R8 F7", 1, 0, 0, 0, 0);

    // F8: error on second payload word
    err_addr = 32'h6004;
    snap(); send(20, 8);
    check("R9 F8 descriptor untouched", mrd(32'h1040), 32'h8000_0000);
    check("R9 F8 cur_desc held", cur_desc, 32'h1040);
    chk_ev("R9 F8", 0, 0, 0, 0, 1);

    // F9: recovery with a clean frame
    err_addr = 32'hFFFF_FFF0;
    snap(); send(8, 9);
    check("R5 F9 status", mrd(32'h1040), 32'h0010_000C);
    chk_store("R4 F9 payload", 32'h6000, 8, 9);
    chk_ev("R12 F9", 1, 0, 0, 0, 0);

    // F10: error on next-pointer read after writeback
    err_addr = 32'h105C;
    snap(); send(4, 10);
    check("R9 F10 status written", mrd(32'h1050), 32'h0010_0008);
    check("R9 F10 cur_desc held", cur_desc, 32'h1050);
    chk_ev("R12 F10", 0, 0, 0, 0, 1);
    err_addr = 32'hFFFF_FFF0;

    // R1: disabled engine holds the stream and reloads the base
    rx_en = 1'b0; list_base = 32'h1010;
    rx_valid = 1'b1; rx_data = 8'h5A; rx_last = 1'b1; saw = 1'b0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); saw |= rx_ready; end
    rx_valid = 1'b0; rx_last = 1'b0;
    check("R1 disabled rx_ready low", 32'(saw), 0);
    check("R1 disabled cur reload", cur_desc, 32'h1010);

    check("R6 per-cycle cur_desc mismatches", 32'(cyc_bad), 0);
    if (cyc_bad != 0) n_fail += 0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule